// File: doc/BRIEF.md
# Standby Wakeup and Release Controller

This block decides when a small processor system leaves its low-power stop state, and what the core does after it wakes. While the system runs, a stop request gates the core clock off. While stopped, the block watches the reset sources, two non-maskable interrupt sources and a vector of maskable interrupt requests. Each source passes through its own mask and through a global mask for its class. The first cycle that presents a valid wake source starts the release.

On release the clock enable returns at once, and a down-counter loaded from a programmable value measures the oscillator settling interval. When the count reaches zero the block raises a one-cycle action code for the core. The code says branch to a handler, continue at the next instruction, or run a normal reset. With a handler branch it also gives the index of the source being acknowledged. Waking and acknowledging are decided separately. A maskable request wakes the system whatever its priority. It is acknowledged only when interrupts are enabled and it outranks any interrupt that was in service when the system stopped. Otherwise the request stays pending at its source.

Top module: `stby_release_ctrl`

## Requirements
- R1: After the asynchronous reset `rst_ni` is released the controller is in the running state: `clk_en_o` is 1, `action_o` is 0 and `ack_idx_o` is 0.
- R2: A `stop_req_i` sampled while running drops `clk_en_o` to 0 from the next cycle. A `stop_req_i` sampled while the controller is stabilizing or resuming is ignored: it neither changes the release timing nor stops the clock afterwards.
- R3: A non-maskable source `nmi_i[j]` wakes the system only when `nmi_gmask_i[j]` is 0. With the mask bit at 1 that source leaves `clk_en_o` at 0.
- R4: A maskable request `irq_req_i[k]` wakes the system when `irq_mask_i[k]` and `int_gmask_i` are both 0, whatever its priority. With either mask bit at 1 it does not wake the system.
- R5: `clk_en_o` is 1 in the cycle after the wake source is sampled. With a stabilization count K on `stab_cnt_i`, `action_o` is nonzero exactly K+1 cycles after `clk_en_o` rises and stays nonzero for one cycle only.
- R6: A non-maskable wake gives the handler action whether `int_en_i` is 0 or 1. NMI source 0 takes precedence over source 1, and the index reported is 0 or 1 respectively.
- R7: A maskable wake with `int_en_i`=1 and `in_service_i`=0 gives the handler action, with index k+2 for the winning request k. The winner is the request with the smallest `irq_prio_i` field (field k at bits [k*PRIO_W +: PRIO_W]); a tie goes to the lower k. With `int_en_i`=0 the action is next-instruction.
- R8: With `in_service_i`=1, a maskable wake is acknowledged with the handler action only if its priority value is strictly below `isr_prio_i` and `int_en_i` is 1. Otherwise it wakes with the next-instruction action. A non-maskable wake is always acknowledged.
- R9: Any bit of `rst_src_i` wakes the system with the reset action, and it takes precedence over simultaneous interrupt sources.
- R10: `action_o` is one-hot or zero: bit 0 means handler branch, bit 1 means next instruction, bit 2 means reset. `ack_idx_o` is 0 whenever the action is not a handler branch.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Free-running controller clock |
| rst_ni | input | 1 | Asynchronous active-low reset, forces running state |
| stop_req_i | input | 1 | Request to enter the stop state |
| rst_src_i | input | 3 | Reset sources: pin, watchdog, low-voltage detector |
| nmi_i | input | 2 | Non-maskable interrupt requests |
| nmi_gmask_i | input | 2 | Global disable per NMI source, 1 = cannot wake |
| irq_req_i | input | NUM_IRQ | Maskable interrupt requests |
| irq_mask_i | input | NUM_IRQ | Per-request mask, 1 = masked |
| irq_prio_i | input | NUM_IRQ*PRIO_W | Priority per request, smaller value is higher priority |
| int_gmask_i | input | 1 | Global disable of all maskable requests |
| int_en_i | input | 1 | Core interrupt-enable state |
| in_service_i | input | 1 | An interrupt was in service when stop was entered |
| isr_prio_i | input | PRIO_W | Priority of the interrupt in service |
| stab_cnt_i | input | STAB_W | Stabilization interval in cycles |
| clk_en_o | output | 1 | Core clock enable |
| action_o | output | 3 | One-cycle action code after stabilization |
| ack_idx_o | output | IDX_W | Acknowledged source: 0/1 NMI, k+2 maskable k |

## Verification
A wrong state register shows at once on `clk_en_o`. A stop that was never accepted, or a release that never happened, leaves the enable at the wrong level in the very next cycle. A counter that loads the wrong value or skips a step moves the action pulse off the expected cycle, K+1 cycles after the clock returns. A wrong captured cause shows in the action code or index of that one pulse. The sweep covers every subset of four maskable requests under each combination of interrupt enable and in-service state, so a wrong arbitration or acknowledge decision shows up within one release sequence.

// File: rtl/stby_pkg.sv
package stby_pkg;
  typedef enum logic [1:0] {
    ST_RUN    = 2'd0,
    ST_STOP   = 2'd1,
    ST_STAB   = 2'd2,
    ST_RESUME = 2'd3
  } state_e;

  localparam int unsigned ACT_W = 3;
  localparam logic [ACT_W-1:0] ACT_NONE    = 3'b000;
  localparam logic [ACT_W-1:0] ACT_HANDLER = 3'b001;
  localparam logic [ACT_W-1:0] ACT_NEXT    = 3'b010;
  localparam logic [ACT_W-1:0] ACT_RESET   = 3'b100;

  localparam int unsigned NUM_NMI = 2;
  localparam int unsigned NUM_RST = 3;
endpackage

// File: rtl/stby_irq_arbiter.sv
module stby_irq_arbiter #(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned AIDX_W  = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1
) (
  input  logic [NUM_IRQ-1:0]        req_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] prio_i,
  output logic                      grant_o,
  output logic [AIDX_W-1:0]         idx_o,
  output logic [PRIO_W-1:0]         prio_o
);
  // smallest level wins, strict compare keeps lowest index on ties
  always_comb begin
    grant_o = 1'b0;
    idx_o   = '0;
    prio_o  = '1;
    for (int unsigned i = 0; i < NUM_IRQ; i++) begin
      if (req_i[i] && (!grant_o || (prio_i[i*PRIO_W +: PRIO_W] < prio_o))) begin
        grant_o = 1'b1;
        idx_o   = AIDX_W'(i);
        prio_o  = prio_i[i*PRIO_W +: PRIO_W];
      end
    end
  end
endmodule

// File: rtl/stby_stab_counter.sv
module stby_stab_counter #(
  parameter int unsigned STAB_W = 16
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              load_i,
  input  logic [STAB_W-1:0] load_val_i,
  input  logic              dec_i,
  output logic              zero_o
);
  logic [STAB_W-1:0] cnt_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)      cnt_q <= '0;
    else if (load_i)  cnt_q <= load_val_i;
    else if (dec_i && cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero_o = (cnt_q == '0);

  p_count_down_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (dec_i && !load_i && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - 1'b1));

  p_load_value_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    load_i |=> (cnt_q == $past(load_val_i)));
endmodule

// File: rtl/stby_release_fsm.sv
module stby_release_fsm
  import stby_pkg::*;
#(
  parameter int unsigned IDX_W = 4
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             stop_req_i,
  input  logic             wake_i,
  input  logic [ACT_W-1:0] act_i,
  input  logic [IDX_W-1:0] idx_i,
  input  logic             zero_i,
  output logic             load_o,
  output logic             dec_o,
  output logic             clk_en_o,
  output logic [ACT_W-1:0] action_o,
  output logic [IDX_W-1:0] ack_idx_o
);
  state_e           state_q;
  logic [ACT_W-1:0] act_q;
  logic [IDX_W-1:0] idx_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= ST_RUN;
      act_q   <= ACT_NONE;
      idx_q   <= '0;
    end else begin
      unique case (state_q)
        ST_RUN:    if (stop_req_i) state_q <= ST_STOP;
        ST_STOP: begin
          if (wake_i) begin
            state_q <= ST_STAB;
            act_q   <= act_i;
            idx_q   <= idx_i;
          end
        end
        ST_STAB:   if (zero_i) state_q <= ST_RESUME;
        ST_RESUME: state_q <= ST_RUN;
        default:   state_q <= ST_RUN;
      endcase
    end
  end

  assign load_o    = (state_q == ST_STOP) && wake_i;
  assign dec_o     = (state_q == ST_STAB) && !zero_i;
  assign clk_en_o  = (state_q != ST_STOP);
  assign action_o  = (state_q == ST_RESUME) ? act_q : ACT_NONE;
  assign ack_idx_o = ((state_q == ST_RESUME) && (act_q == ACT_HANDLER)) ? idx_q : '0;

  p_stop_gates_clock_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (state_q == ST_RUN && stop_req_i) |=> !clk_en_o);

  p_action_after_stab_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (action_o != ACT_NONE) |-> ($past(state_q) == ST_STAB));

  p_action_pulse_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (action_o != ACT_NONE) |=> (action_o == ACT_NONE));

  p_action_onehot_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(action_o));
endmodule

// File: rtl/stby_release_ctrl.sv
module stby_release_ctrl
  import stby_pkg::*;
#(
  parameter int unsigned NUM_IRQ = 8,
  parameter int unsigned PRIO_W  = 3,
  parameter int unsigned STAB_W  = 16,
  parameter int unsigned IDX_W   = $clog2(NUM_IRQ + 2)
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      stop_req_i,
  input  logic [2:0]                rst_src_i,
  input  logic [1:0]                nmi_i,
  input  logic [1:0]                nmi_gmask_i,
  input  logic [NUM_IRQ-1:0]        irq_req_i,
  input  logic [NUM_IRQ-1:0]        irq_mask_i,
  input  logic [NUM_IRQ*PRIO_W-1:0] irq_prio_i,
  input  logic                      int_gmask_i,
  input  logic                      int_en_i,
  input  logic                      in_service_i,
  input  logic [PRIO_W-1:0]         isr_prio_i,
  input  logic [STAB_W-1:0]         stab_cnt_i,
  output logic                      clk_en_o,
  output logic [2:0]                action_o,
  output logic [IDX_W-1:0]          ack_idx_o
);
  localparam int unsigned AIDX_W = (NUM_IRQ > 1) ? $clog2(NUM_IRQ) : 1;

  logic                rst_any;
  logic [1:0]          nmi_v;
  logic [NUM_IRQ-1:0]  irq_v;
  logic                arb_grant;
  logic [AIDX_W-1:0]   arb_idx;
  logic [PRIO_W-1:0]   arb_prio;
  logic                wake;
  logic [ACT_W-1:0]    act_sel;
  logic [IDX_W-1:0]    idx_sel;
  logic                irq_acked;
  logic                load, dec, zero;

  assign rst_any = |rst_src_i;
  assign nmi_v   = nmi_i & ~nmi_gmask_i;
  assign irq_v   = irq_req_i & ~irq_mask_i & {NUM_IRQ{~int_gmask_i}};

  stby_irq_arbiter #(
    .NUM_IRQ (NUM_IRQ),
    .PRIO_W  (PRIO_W),
    .AIDX_W  (AIDX_W)
  ) u_arb (
    .req_i   (irq_v),
    .prio_i  (irq_prio_i),
    .grant_o (arb_grant),
    .idx_o   (arb_idx),
    .prio_o  (arb_prio)
  );

  // wake ignores priority; acknowledge needs EI and a higher level than in service
  assign irq_acked = int_en_i && (!in_service_i || (arb_prio < isr_prio_i));
  assign wake      = rst_any || (|nmi_v) || arb_grant;

  always_comb begin
    act_sel = ACT_NONE;
    idx_sel = '0;
    if (rst_any) begin
      act_sel = ACT_RESET;
    end else if (nmi_v[0]) begin
      act_sel = ACT_HANDLER;
    end else if (nmi_v[1]) begin
      act_sel = ACT_HANDLER;
      idx_sel = IDX_W'(1);
    end else if (arb_grant) begin
      if (irq_acked) begin
        act_sel = ACT_HANDLER;
        idx_sel = IDX_W'(arb_idx) + IDX_W'(NUM_NMI);
      end else begin
        act_sel = ACT_NEXT;
      end
    end
  end

  stby_stab_counter #(
    .STAB_W (STAB_W)
  ) u_cnt (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .load_i     (load),
    .load_val_i (stab_cnt_i),
    .dec_i      (dec),
    .zero_o     (zero)
  );

  stby_release_fsm #(
    .IDX_W (IDX_W)
  ) u_fsm (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .stop_req_i (stop_req_i),
    .wake_i     (wake),
    .act_i      (act_sel),
    .idx_i      (idx_sel),
    .zero_i     (zero),
    .load_o     (load),
    .dec_o      (dec),
    .clk_en_o   (clk_en_o),
    .action_o   (action_o),
    .ack_idx_o  (ack_idx_o)
  );

  p_grant_is_valid_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    arb_grant |-> irq_v[arb_idx]);

  p_idx_only_handler_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (action_o != ACT_HANDLER) |-> (ack_idx_o == '0));

  p_clock_back_on_wake_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!clk_en_o && wake) |=> clk_en_o);
endmodule

// File: tb/stby_release_ctrl_tb.sv
module stby_release_ctrl_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int N  = 4;
  localparam int PW = 2;
  localparam int SW = 8;
  localparam int IW = $clog2(N + 2);

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic          stop_req_i = 1'b0;
  logic [2:0]    rst_src_i = '0;
  logic [1:0]    nmi_i = '0;
  logic [1:0]    nmi_gmask_i = '0;
  logic [N-1:0]  irq_req_i = '0;
  logic [N-1:0]  irq_mask_i = '0;
  logic [N*PW-1:0] irq_prio_i = '0;
  logic          int_gmask_i = 1'b0;
  logic          int_en_i = 1'b0;
  logic          in_service_i = 1'b0;
  logic [PW-1:0] isr_prio_i = '0;
  logic [SW-1:0] stab_cnt_i = '0;
  logic          clk_en_o;
  logic [2:0]    action_o;
  logic [IW-1:0] ack_idx_o;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  always #(CLK_PERIOD/2) clk_i = ~clk_i;

  stby_release_ctrl #(.NUM_IRQ(N), .PRIO_W(PW), .STAB_W(SW)) dut_i (.*);

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic clear_src();
    rst_src_i = '0; nmi_i = '0; nmi_gmask_i = '0; irq_req_i = '0;
    irq_mask_i = '0; int_gmask_i = 0; int_en_i = 0; in_service_i = 0;
  endtask

  task automatic enter_stop();
    stop_req_i = 1;
    step();
    stop_req_i = 0;
    chk(clk_en_o == 0, "R2 clock off after stop", clk_en_o, 0);
  endtask

  // sources already driven; expects wake at next edge
  task automatic release_seq(input int k, input int exp_act, input int exp_idx,
                             input string req, input bit poke_stop);
    stab_cnt_i = SW'(k);
    step();
    chk(clk_en_o == 1, "R5 clock back after wake", clk_en_o, 1);
    clear_src();
    for (int j = 1; j <= k; j++) begin
      if (poke_stop && j == 1) stop_req_i = 1;
      step();
      stop_req_i = 0;
      chk(action_o == 0, "R5 no action before count ends", action_o, 0);
    end
    step();
    chk(action_o == 3'(exp_act), req, action_o, exp_act);
    chk(ack_idx_o == IW'(exp_idx), {req, " index"}, ack_idx_o, exp_idx);
    step();
    chk(action_o == 0 && clk_en_o == 1, "R5 single pulse then run", action_o, 0);
  endtask

  initial begin
    #(CLK_PERIOD * 150000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%0d expected=%0d", 1, 0);
      $display("  CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    int exp_act, exp_idx, best, bp, pr;
    @(negedge clk_i);
    rst_ni = 1;
    step();
    chk(clk_en_o == 1, "R1 reset clock enabled", clk_en_o, 1);
    chk(action_o == 0, "R1 reset no action", action_o, 0);
    chk(ack_idx_o == 0, "R1 reset index", ack_idx_o, 0);

    // R6 NMI handler regardless of int_en
    enter_stop();
    nmi_i = 2'b01; int_en_i = 0;
    release_seq(3, 1, 0, "R6 nmi0 handler with DI", 0);
    enter_stop();
    nmi_i = 2'b11; nmi_gmask_i = 2'b01; int_en_i = 1;
    release_seq(0, 1, 1, "R6 nmi1 handler when nmi0 masked", 0);
    enter_stop();
    nmi_i = 2'b11; irq_req_i = 4'b0001;
    release_seq(1, 1, 0, "R6 nmi0 beats nmi1", 0);
    // R8 NMI during in-service
    enter_stop();
    nmi_i = 2'b10; in_service_i = 1; isr_prio_i = 0;
    release_seq(2, 1, 1, "R8 nmi acked while in service", 0);

    // R3/R4 masked sources do not wake
    enter_stop();
    nmi_i = 2'b11; nmi_gmask_i = 2'b11;
    irq_req_i = 4'b0110; irq_mask_i = 4'b0110;
    step(); step();
    chk(clk_en_o == 0, "R3 masked nmi no wake", clk_en_o, 0);
    irq_req_i = 4'b1111; irq_mask_i = 4'b0000; int_gmask_i = 1;
    step(); step();
    chk(clk_en_o == 0, "R4 global irq mask no wake", clk_en_o, 0);
    // R9 reset source beats interrupts
    rst_src_i = 3'b010; nmi_gmask_i = 0; int_gmask_i = 0;
    release_seq(2, 4, 0, "R9 reset action", 0);
    enter_stop();
    rst_src_i = 3'b100;
    release_seq(0, 4, 0, "R9 low-voltage reset action", 0);

    // R2 stop request ignored while stabilizing
    enter_stop();
    irq_req_i = 4'b0100; int_en_i = 1;
    irq_prio_i = '0;
    release_seq(4, 1, 4, "R2 stop ignored in stabilize", 1);
    step();
    chk(clk_en_o == 1, "R2 stop not latched", clk_en_o, 1);

    // R4 R7 R8 sweep over request subsets and core state
    for (int pat = 1; pat < (1 << N); pat++) begin
      for (int mode = 0; mode < 4; mode++) begin
        enter_stop();
        for (int k = 0; k < N; k++) irq_prio_i[k*PW +: PW] = PW'((k * 3 + pat) % 4);
        irq_req_i = N'(pat);
        int_en_i = mode[0];
        in_service_i = mode[1];
        isr_prio_i = 2;
        best = -1; bp = 0;
        for (int k = 0; k < N; k++) begin
          pr = (k * 3 + pat) % 4;
          if (pat[k] && (best < 0 || pr < bp)) begin best = k; bp = pr; end
        end
        if (mode[0] && (!mode[1] || bp < 2)) begin exp_act = 1; exp_idx = best + 2; end
        else begin exp_act = 2; exp_idx = 0; end
        release_seq(pat % 3, exp_act, exp_idx,
                    mode[1] ? "R8 in-service acknowledge rule" : "R7 maskable action", 0);
      end
    end

    done = 1;
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule